// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents one interrupt to a processor. The processor sees it as a 3-bit priority level and an 8-bit vector number. Each source has four pieces of state: a captured request bit, a software force bit, a mask bit, and an 8-bit priority byte. Writing the priority byte also turns the source on or off. A source takes part in arbitration only if it is requested or forced, enabled, and not masked.

Among the sources that take part, the one with the largest priority byte wins. When two sources share that byte, the higher-numbered one wins. The winner's number plus 64 becomes the vector. When no source takes part, the vector is the spurious value 24 and the level is 0.

Software reaches everything through a byte-addressed window of 256 offsets. Each 64-bit register appears as two 32-bit words, with the upper word at the lower offset. Two command offsets set or clear a single mask bit by source number. An acknowledge offset returns the current vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the level is 0 and the vector is 24. Every mask bit reads 1. Every force bit and every priority byte reads 0.
- R2: A source is active when (request bit OR force bit) AND enable bit AND NOT mask bit. An inactive source never sets the vector.
- R3: Among active sources, the largest 8-bit priority byte wins. The full byte is compared. On equal bytes, the higher source number wins.
- R4: The vector is the winning source number plus 64. The level is bits 2:0 of the winner's priority byte. With no active source, the vector is 24 and the level is 0.
- R5: Offset 0x40+n holds the priority byte of source n. A write stores bits 7:0 of the data. A zero byte disables the source and a non-zero byte enables it. A read returns the byte zero-extended.
- R6: The request bits capture the input lines on every clock. Offset 0x00 reads bits 63:32 and offset 0x04 reads bits 31:0. Writes to 0x00 and 0x04 change nothing.
- R7: The mask words are at 0x08 (bits 63:32) and 0x0C (bits 31:0). The force words are at 0x10 (bits 63:32) and 0x14 (bits 31:0). All four are read and written as full 32-bit words.
- R8: A write to 0x1C sets the mask bit named by data bits 5:0. A write to 0x1D clears it. No other bit changes.
- R9: A read of 0xE0 returns the current vector, zero-extended. Reads of 0xE1 to 0xE7 return 0.
- R10: The level and vector are registered. After a register write at clock edge k, they change at edge k+1. After an input line changes before edge k, they change at edge k+1, since the request bit is captured at edge k.
- R11: Writes to offsets outside 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x1D and 0x40 to 0x7F change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_level | output | 3 | Priority level presented to the processor |
| irq_vector | output | 8 | Vector of the selected source, or 24 |

## Verification
Corrupt mask, force or enable state shows up one clock later as the wrong vector. It also reads back wrongly at once through the word offsets. A mis-ordered comparison in the selection logic only shows when active sources have equal or out-of-order priority bytes. The bench therefore builds ties and cases where the byte and its low three bits rank sources differently. A lost or stale request capture shows as a vector that lags the input by one clock too many. The bench checks the vector on both edges after each input change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_FRC_HI  = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_FRC_LO  = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_MSET    = 8'h1C;
   localparam logic [ADDR_W-1:0] OFS_MCLR    = 8'h1D;
   localparam logic [ADDR_W-1:0] OFS_ACK     = 8'hE0;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_MASK_HI,
      ACC_MASK_LO,
      ACC_FRC_HI,
      ACC_FRC_LO,
      ACC_MSET,
      ACC_MCLR,
      ACC_PRIO
   } acc_e;

   function automatic acc_e decode_acc(input logic [ADDR_W-1:0] a);
      acc_e r;
      if (a[7:6] == 2'b01) begin
         r = ACC_PRIO;
      end else begin
         case (a)
            OFS_MASK_HI: r = ACC_MASK_HI;
            OFS_MASK_LO: r = ACC_MASK_LO;
            OFS_FRC_HI:  r = ACC_FRC_HI;
            OFS_FRC_LO:  r = ACC_FRC_LO;
            OFS_MSET:    r = ACC_MSET;
            OFS_MCLR:    r = ACC_MCLR;
            default:     r = ACC_NONE;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int PRIO_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NSRC-1:0]               irq_i,
   input  logic                          bus_wr,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [NSRC-1:0]               pend_q,
   output logic [NSRC-1:0]               force_q,
   output logic [NSRC-1:0]               mask_q,
   output logic [NSRC-1:0]               enable_q,
   output logic [NSRC-1:0][PRIO_W-1:0]   prio_q
);

   localparam int SEL_W = $clog2(NSRC);

   acc_e             acc;
   logic [SEL_W-1:0] bit_sel;
   logic [SEL_W-1:0] slot_sel;

   assign acc      = bus_wr ? decode_acc(bus_addr) : ACC_NONE;
   assign bit_sel  = bus_wdata[SEL_W-1:0];
   assign slot_sel = bus_addr[SEL_W-1:0];

   // request capture: one flop per line, no software path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= irq_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else begin
         case (acc)
            ACC_MASK_HI: mask_q[NSRC-1:DATA_W] <= bus_wdata;
            ACC_MASK_LO: mask_q[DATA_W-1:0]    <= bus_wdata;
            ACC_MSET:    mask_q[bit_sel]       <= 1'b1;
            ACC_MCLR:    mask_q[bit_sel]       <= 1'b0;
            default:     ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= '0;
      end else begin
         case (acc)
            ACC_FRC_HI: force_q[NSRC-1:DATA_W] <= bus_wdata;
            ACC_FRC_LO: force_q[DATA_W-1:0]    <= bus_wdata;
            default:    ;
         endcase
      end
   end

   // one priority byte and its enable per source
   for (genvar s = 0; s < NSRC; s++) begin : g_slot
      logic hit;
      assign hit = (acc == ACC_PRIO) && (slot_sel == SEL_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[s]   <= '0;
            enable_q[s] <= 1'b0;
         end else if (hit) begin
            prio_q[s]   <= bus_wdata[PRIO_W-1:0];
            enable_q[s] <= |bus_wdata[PRIO_W-1:0];
         end
      end
   end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
   parameter int NSRC     = 64,
   parameter int PRIO_W   = 8,
   parameter int SEL_TREE = 1
) (
   input  logic [NSRC-1:0]              active,
   input  logic [NSRC-1:0][PRIO_W-1:0]  prio,
   output logic                         found,
   output logic [$clog2(NSRC)-1:0]      best_idx,
   output logic [PRIO_W-1:0]            best_pri
);

   localparam int IDX_W = $clog2(NSRC);
   localparam int NODES = 2*NSRC - 1;

   if (SEL_TREE != 0) begin : g_tree
      // heap-ordered tournament: node n has children 2n+1 (lower sources)
      // and 2n+2 (higher sources); leaves sit at NSRC-1+s
      logic             nv [NODES];
      logic [PRIO_W-1:0] np [NODES];
      logic [IDX_W-1:0]  ni [NODES];

      for (genvar s = 0; s < NSRC; s++) begin : g_leaf
         assign nv[NSRC-1+s] = active[s];
         assign np[NSRC-1+s] = prio[s];
         assign ni[NSRC-1+s] = IDX_W'(s);
      end

      for (genvar n = 0; n < NSRC-1; n++) begin : g_node
         logic take_hi;
         // the higher half wins ties, matching an upward scan with >=
         assign take_hi = nv[2*n+2] && (!nv[2*n+1] || (np[2*n+2] >= np[2*n+1]));
         assign nv[n]   = nv[2*n+1] | nv[2*n+2];
         assign np[n]   = take_hi ? np[2*n+2] : np[2*n+1];
         assign ni[n]   = take_hi ? ni[2*n+2] : ni[2*n+1];
      end

      assign found    = nv[0];
      assign best_idx = ni[0];
      assign best_pri = np[0];
   end else begin : g_scan
      always_comb begin
         found    = 1'b0;
         best_idx = '0;
         best_pri = '0;
         for (int s = 0; s < NSRC; s++) begin
            if (active[s] && (prio[s] >= best_pri)) begin
               found    = 1'b1;
               best_idx = IDX_W'(s);
               best_pri = prio[s];
            end
         end
      end
   end

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
   import irqc_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int PRIO_W = 8,
   parameter int DATA_W = 32,
   parameter int VEC_W  = 8
) (
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [NSRC-1:0]              pend_q,
   input  logic [NSRC-1:0]              mask_q,
   input  logic [NSRC-1:0]              force_q,
   input  logic [NSRC-1:0][PRIO_W-1:0]  prio_q,
   input  logic [VEC_W-1:0]             vector,
   output logic [DATA_W-1:0]            bus_rdata
);

   localparam int SEL_W = $clog2(NSRC);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[7:6] == 2'b01) begin
         bus_rdata = DATA_W'(prio_q[bus_addr[SEL_W-1:0]]);
      end else begin
         case (bus_addr)
            OFS_PEND_HI: bus_rdata = pend_q[NSRC-1:DATA_W];
            OFS_PEND_LO: bus_rdata = pend_q[DATA_W-1:0];
            OFS_MASK_HI: bus_rdata = mask_q[NSRC-1:DATA_W];
            OFS_MASK_LO: bus_rdata = mask_q[DATA_W-1:0];
            OFS_FRC_HI:  bus_rdata = force_q[NSRC-1:DATA_W];
            OFS_FRC_LO:  bus_rdata = force_q[DATA_W-1:0];
            OFS_ACK:     bus_rdata = DATA_W'(vector);
            default:     bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NSRC     = 64,
   parameter int PRIO_W   = 8,
   parameter int LVL_W    = 3,
   parameter int DATA_W   = 32,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64,
   parameter int SPUR_VEC = 24,
   parameter int SEL_TREE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       irq_i,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [2:0]        irq_level,
   output logic [7:0]        irq_vector
);

   localparam int IDX_W = $clog2(NSRC);

   if (NSRC != 2*DATA_W) begin : g_bad_nsrc
      $error("NSRC must be two data words wide");
   end
   if (NSRC != 64 || DATA_W != 32 || LVL_W != 3 || VEC_W != 8) begin : g_bad_port
      $error("port widths are fixed by the register window");
   end
   if (LVL_W > PRIO_W || PRIO_W > DATA_W) begin : g_bad_prio
      $error("priority byte width out of range");
   end
   if (VEC_BASE + NSRC > 2**VEC_W || SPUR_VEC >= 2**VEC_W) begin : g_bad_vec
      $error("vector values do not fit VEC_W");
   end

   logic [NSRC-1:0]              pend_q;
   logic [NSRC-1:0]              force_q;
   logic [NSRC-1:0]              mask_q;
   logic [NSRC-1:0]              enable_q;
   logic [NSRC-1:0][PRIO_W-1:0]  prio_q;
   logic [NSRC-1:0]              active;
   logic                         found;
   logic [IDX_W-1:0]             best_idx;
   logic [PRIO_W-1:0]            best_pri;
   logic [VEC_W-1:0]             vec_d;
   logic [LVL_W-1:0]             lvl_d;

   irqc_regs #(
      .NSRC   (NSRC),
      .PRIO_W (PRIO_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_i     (irq_i),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pend_q    (pend_q),
      .force_q   (force_q),
      .mask_q    (mask_q),
      .enable_q  (enable_q),
      .prio_q    (prio_q)
   );

   assign active = (pend_q | force_q) & enable_q & ~mask_q;

   irqc_select #(
      .NSRC     (NSRC),
      .PRIO_W   (PRIO_W),
      .SEL_TREE (SEL_TREE)
   ) u_sel (
      .active   (active),
      .prio     (prio_q),
      .found    (found),
      .best_idx (best_idx),
      .best_pri (best_pri)
   );

   assign vec_d = found ? (VEC_W'(VEC_BASE) + VEC_W'(best_idx)) : VEC_W'(SPUR_VEC);
   assign lvl_d = found ? best_pri[LVL_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_vector <= VEC_W'(SPUR_VEC);
         irq_level  <= '0;
      end else begin
         irq_vector <= vec_d;
         irq_level  <= lvl_d;
      end
   end

   irqc_rdmux #(
      .NSRC   (NSRC),
      .PRIO_W (PRIO_W),
      .DATA_W (DATA_W),
      .VEC_W  (VEC_W)
   ) u_rd (
      .bus_addr  (bus_addr),
      .pend_q    (pend_q),
      .mask_q    (mask_q),
      .force_q   (force_q),
      .prio_q    (prio_q),
      .vector    (irq_vector),
      .bus_rdata (bus_rdata)
   );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [63:0] irq_i,
   input logic        bus_wr,
   input logic [7:0]  bus_addr,
   input logic [31:0] bus_wdata,
   input logic [63:0] pend_q,
   input logic [63:0] mask_q,
   input logic [63:0] enable_q,
   input logic [2:0]  irq_level,
   input logic [7:0]  irq_vector
);

   a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vector == 8'd24) || (irq_vector >= 8'd64 && irq_vector <= 8'd127));

   a_r4_spur_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vector == 8'd24) |-> (irq_level == 3'd0));

   a_r6_pend_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (pend_q == $past(irq_i)));

   a_r8_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h1C) |=> mask_q[$past(bus_wdata[5:0])]);

   a_r8_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h1D) |=> !mask_q[$past(bus_wdata[5:0])]);

   a_r5_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[7:6] == 2'b01 && bus_wdata[7:0] == 8'd0)
      |=> !enable_q[$past(bus_addr[5:0])]);

   a_r5_nonzero_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[7:6] == 2'b01 && bus_wdata[7:0] != 8'd0)
      |=> enable_q[$past(bus_addr[5:0])]);

endmodule

bind prio_irq_ctrl irqc_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_i      (irq_i),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .pend_q     (pend_q),
   .mask_q     (mask_q),
   .enable_q   (enable_q),
   .irq_level  (irq_level),
   .irq_vector (irq_vector)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_i = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq_level;
   logic [7:0]  irq_vector;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_i      (irq_i),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_level  (irq_level),
      .irq_vector (irq_vector)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string what);
      bus_addr = a;
      #1;
      chk(bus_rdata === exp, what, bus_rdata, exp);
   endtask

   task automatic out_chk(input logic [7:0] vec, input logic [2:0] lvl, input string what);
      chk(irq_vector === vec, {what, " vector"}, 32'(irq_vector), 32'(vec));
      chk(irq_level === lvl, {what, " level"}, 32'(irq_level), 32'(lvl));
   endtask

   task automatic t_reset();
      out_chk(8'd24, 3'd0, "R1 reset outputs");
      rd_chk(8'h08, 32'hFFFF_FFFF, "R1 reset mask hi");
      rd_chk(8'h0C, 32'hFFFF_FFFF, "R1 reset mask lo");
      rd_chk(8'h10, 32'h0, "R1 reset force hi");
      rd_chk(8'h14, 32'h0, "R1 reset force lo");
      rd_chk(8'h40, 32'h0, "R1 reset prio src0");
      rd_chk(8'h7F, 32'h0, "R1 reset prio src63");
   endtask

   task automatic t_basic();
      wr(8'h45, 32'h3);
      wr(8'h1D, 32'd5);
      settle();
      out_chk(8'd24, 3'd0, "R2 no request yet");
      irq_i[5] = 1'b1;
      settle();
      out_chk(8'd24, 3'd0, "R10 one edge after input");
      settle();
      out_chk(8'd69, 3'd3, "R4 src5 selected");
   endtask

   task automatic t_mask_cmd();
      wr(8'h1C, 32'd5);
      out_chk(8'd69, 3'd3, "R10 write edge outputs unchanged");
      settle();
      out_chk(8'd24, 3'd0, "R8 set mask bit hides src5");
      rd_chk(8'h0C, 32'hFFFF_FFFF, "R8 mask lo after set");
      wr(8'h1D, 32'd69);
      settle();
      out_chk(8'd69, 3'd3, "R8 clear uses low 6 bits");
      rd_chk(8'h0C, 32'hFFFF_FFDF, "R8 mask lo after clear");
   endtask

   task automatic t_enable();
      wr(8'h45, 32'h0);
      settle();
      out_chk(8'd24, 3'd0, "R5 zero byte disables");
      rd_chk(8'h45, 32'h0, "R5 prio src5 reads zero");
      wr(8'h45, 32'hFFFF_FF0A);
      settle();
      out_chk(8'd69, 3'd2, "R5 nonzero byte enables");
      rd_chk(8'h45, 32'h0000_000A, "R5 prio src5 readback");
      irq_i = '0;
      settle();
      settle();
      out_chk(8'd24, 3'd0, "R2 request dropped");
   endtask

   task automatic t_force();
      wr(8'h14, 32'h0000_0080);
      wr(8'h47, 32'd6);
      wr(8'h1D, 32'd7);
      settle();
      out_chk(8'd71, 3'd6, "R7 force lo drives src7");
      wr(8'h10, 32'h0000_0100);
      wr(8'h68, 32'd6);
      wr(8'h1D, 32'd40);
      settle();
      out_chk(8'd104, 3'd6, "R3 tie goes to higher source");
      wr(8'h47, 32'd9);
      settle();
      out_chk(8'd71, 3'd1, "R3 full byte compared, R4 level truncated");
      rd_chk(8'h14, 32'h0000_0080, "R7 force lo readback");
      rd_chk(8'h10, 32'h0000_0100, "R7 force hi readback");
      rd_chk(8'h08, 32'hFFFF_FEFF, "R7 mask hi readback");
   endtask

   task automatic t_pending();
      wr(8'h14, 32'h0);
      wr(8'h10, 32'h0);
      settle();
      out_chk(8'd24, 3'd0, "R2 force cleared");
      @(negedge clk);
      irq_i = 64'h1234_5678_0000_3C3C;
      settle();
      settle();
      out_chk(8'd69, 3'd2, "R2 only enabled unmasked request wins");
      rd_chk(8'h00, 32'h1234_5678, "R6 pending hi");
      rd_chk(8'h04, 32'h0000_3C3C, "R6 pending lo");
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 32'h0);
      rd_chk(8'h00, 32'h1234_5678, "R6 pending hi write ignored");
      rd_chk(8'h04, 32'h0000_3C3C, "R6 pending lo write ignored");
      settle();
      out_chk(8'd69, 3'd2, "R6 outputs after ignored writes");
   endtask

   task automatic t_unknown();
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h18, 32'h0);
      wr(8'h1E, 32'd5);
      wr(8'h80, 32'hFF);
      wr(8'hE0, 32'h0);
      wr(8'hC5, 32'h0);
      settle();
      rd_chk(8'h08, 32'hFFFF_FEFF, "R11 mask hi untouched");
      rd_chk(8'h0C, 32'hFFFF_FF5F, "R11 mask lo untouched");
      rd_chk(8'h10, 32'h0, "R11 force hi untouched");
      rd_chk(8'h14, 32'h0, "R11 force lo untouched");
      rd_chk(8'h40, 32'h0, "R11 prio src0 untouched");
      rd_chk(8'h45, 32'h0000_000A, "R11 prio src5 untouched");
      out_chk(8'd69, 3'd2, "R11 outputs untouched");
   endtask

   task automatic t_ack();
      rd_chk(8'hE0, 32'd69, "R9 acknowledge returns vector");
      for (int a = 8'hE1; a <= 8'hE7; a++) begin
         rd_chk(8'(a), 32'h0, "R9 upper acknowledge reads zero");
      end
   endtask

   task automatic t_mask_words();
      wr(8'h08, 32'h0);
      rd_chk(8'h08, 32'h0, "R7 mask hi word write");
      wr(8'h0C, 32'hFFFF_FFFF);
      rd_chk(8'h0C, 32'hFFFF_FFFF, "R7 mask lo word write");
      settle();
      out_chk(8'd24, 3'd0, "R7 full mask word hides src5");
      rd_chk(8'hE0, 32'd24, "R9 acknowledge spurious");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_basic();
      t_mask_cmd();
      t_enable();
      t_force();
      t_pending();
      t_unknown();
      t_ack();
      t_mask_words();
      finish_run();
   end

endmodule